// File: doc/BRIEF.md
# Four-Channel Interval Timer Bank

This block holds four identical up-counting timer channels behind a small word-addressed register bus. Software controls each channel through command writes. Writing any value to one command location resets the channel, writing to another enables it and writing to a third disables it. Separate registers set the mode, the terminal value and interrupt gating. Each channel advances only on cycles where its own tick qualifier is high, so an external prescaler can pace each channel at its own rate. A shared clock-request bit gates counting in all four channels at once.

When a channel reaches its terminal value it raises a pending flag. In continuous mode it then starts again from zero. In one-shot mode it stops and drops its enable. Each channel drives a level interrupt: the pending flag gated by the channel's interrupt-enable bit. Software clears the flag by writing bit 7 to the channel's acknowledge location. A terminal value of all ones together with continuous mode gives a free-running timestamp counter.

The register bus has no handshake. A write takes effect on the clock edge where the write strobe is sampled. Read data is registered on the edge where the read strobe is sampled and is then held.

Top module: `interval_timer_bank`

## Requirements
- R1: Channel n has its registers at base n*0x40, with these offsets: 0x00 reset, 0x04 enable, 0x08 disable, 0x0C mode, 0x10 status, 0x14 count, 0x18 terminal and 0x1C interrupt enable. Acknowledge is at offset 0x20. Clock request is at 0x100, bit 0. Reads of the write-only offsets (0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20) and of unmapped addresses return 0. Clock request reads back its value.
- R2: A write to the reset, enable or disable offset performs that command whatever the data. At most one command strobe is active per cycle.
- R3: The count rises by exactly 1 on each cycle where the channel is enabled, its tick input is high and clock request bit 0 is 1. On every other cycle the count holds, so disable freezes it.
- R4: A tick whose incremented count equals the terminal value sets pending. A terminal value of 1 gives an event on the first tick after a reset.
- R5: In continuous mode (mode bit 0 = 0) the count returns to 0 at the event and keeps running, so events repeat every terminal-value ticks.
- R6: In one-shot mode (mode bit 0 = 1) the count stops at the terminal value at the event, enable clears and the state becomes idle.
- R7: The status word is laid out as follows. Bits [3:0] hold the state: 1 when idle (disabled), 2 when active (enabled). Bit 4 is enable, bit 5 is mode, bit 6 is interrupt-enable and bit 7 is pending. All other bits are 0.
- R8: The interrupt output equals pending AND interrupt-enable bit 0. An acknowledge write with bit 7 set clears pending. An acknowledge without bit 7 has no effect. An event in the same cycle as an acknowledge leaves pending set.
- R9: The reset command clears the count and pending. It keeps the mode, terminal value, interrupt-enable and enable settings.
- R10: Read data appears the cycle after the read strobe and holds until the next read.
- R11: After hardware reset every channel has count 0, is disabled, in continuous mode, with terminal value 0xFFFFFFFF, interrupt disabled and nothing pending. Clock request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 4 | Per-channel count qualifier |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The hardest case to reach is an acknowledge write in the very cycle in which the channel hits its terminal value again. The acknowledge must lose, so the interrupt is not dropped. The stimulus sets a terminal value of 1 in continuous mode, so every tick is an event, and then issues the acknowledge write with the tick held high in that same cycle. The one-shot halt, where the count parks at the terminal value and enable drops, is reached the same way. Both are then read back through the status and count registers.

// File: rtl/itv_pkg.sv
package itv_pkg;
  localparam logic [5:0] OFS_RST    = 6'h00;
  localparam logic [5:0] OFS_ENA    = 6'h04;
  localparam logic [5:0] OFS_DIS    = 6'h08;
  localparam logic [5:0] OFS_MODE   = 6'h0C;
  localparam logic [5:0] OFS_STAT   = 6'h10;
  localparam logic [5:0] OFS_COUNT  = 6'h14;
  localparam logic [5:0] OFS_TERM   = 6'h18;
  localparam logic [5:0] OFS_IE     = 6'h1C;
  localparam logic [5:0] OFS_ACK    = 6'h20;

  localparam logic [3:0] ST_IDLE    = 4'd1;
  localparam logic [3:0] ST_ACTIVE  = 4'd2;

  typedef struct packed {
    logic rst;
    logic ena;
    logic dis;
    logic mode;
    logic term;
    logic ie;
    logic ack;
  } chan_cmd_t;

  function automatic logic [7:0] pack_status(input logic en, input logic mode,
                                             input logic ie, input logic pend);
    return {pend, ie, mode, en, (en ? ST_ACTIVE : ST_IDLE)};
  endfunction
endpackage

// File: rtl/itv_decode.sv
module itv_decode
  import itv_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  output chan_cmd_t [NCH-1:0]  cmd,
  output logic                 clkreq_we
);
  localparam int CHB = AW - 6;
  localparam logic [AW-1:0] CLKREQ_ADDR = AW'(256);

  logic [5:0] ofs;
  assign ofs = addr[5:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr && (addr[AW-1:6] == CHB'(i));
    assign cmd[i].rst  = hit && (ofs == OFS_RST);
    assign cmd[i].ena  = hit && (ofs == OFS_ENA);
    assign cmd[i].dis  = hit && (ofs == OFS_DIS);
    assign cmd[i].mode = hit && (ofs == OFS_MODE);
    assign cmd[i].term = hit && (ofs == OFS_TERM);
    assign cmd[i].ie   = hit && (ofs == OFS_IE);
    assign cmd[i].ack  = hit && (ofs == OFS_ACK);
  end

  assign clkreq_we = wr && (addr == CLKREQ_ADDR);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd, clkreq_we})); // R2
endmodule

// File: rtl/itv_channel.sv
module itv_channel
  import itv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_cmd_t     cmd,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          clkreq,
  output logic [DW-1:0] count,
  output logic [DW-1:0] term,
  output logic [7:0]    status,
  output logic          irq
);
  logic [DW-1:0] count_q, term_q, nxt;
  logic en_q, mode_q, ie_q, pend_q;
  logic adv, hit;

  assign nxt = count_q + DW'(1);
  assign hit = (nxt == term_q);
  assign adv = en_q && tick && clkreq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      term_q  <= '1;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      ie_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (cmd.mode) mode_q <= wdata[0];
      if (cmd.term) term_q <= wdata;
      if (cmd.ie)   ie_q   <= wdata[0];
      if (cmd.ena)      en_q <= 1'b1;
      else if (cmd.dis) en_q <= 1'b0;
      if (cmd.ack && wdata[7]) pend_q <= 1'b0;
      if (cmd.rst) begin
        count_q <= '0;
        pend_q  <= 1'b0;
      end else if (adv) begin
        if (hit) begin
          pend_q <= 1'b1;
          if (mode_q) begin
            count_q <= nxt;
            en_q    <= 1'b0;
          end else begin
            count_q <= '0;
          end
        end else begin
          count_q <= nxt;
        end
      end
    end
  end

  assign count  = count_q;
  assign term   = term_q;
  assign status = pack_status(en_q, mode_q, ie_q, pend_q);
  assign irq    = pend_q && ie_q;

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cmd.rst) |=> $stable(count_q)); // R3
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.rst |=> (count_q == $past(count_q) || count_q == $past(count_q) + DW'(1)
                  || count_q == '0)); // R5
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend_q) && $past(mode_q)) |-> !en_q); // R6
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rst |=> (count_q == '0 && !pend_q)); // R9
endmodule

// File: rtl/itv_rdmux.sv
module itv_rdmux
  import itv_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 9,
  parameter int DW  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd,
  input  logic [AW-1:0]            addr,
  input  logic [NCH-1:0][DW-1:0]   counts,
  input  logic [NCH-1:0][DW-1:0]   terms,
  input  logic [NCH-1:0][7:0]      stats,
  input  logic                     clkreq,
  output logic [DW-1:0]            rdata
);
  localparam int CHB = AW - 6;
  localparam logic [AW-1:0] CLKREQ_ADDR = AW'(256);

  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr[AW-1:6] == CHB'(i)) begin
        case (addr[5:0])
          OFS_STAT:  sel = DW'(stats[i]);
          OFS_COUNT: sel = counts[i];
          OFS_TERM:  sel = terms[i];
          default:   sel = '0;
        endcase
      end
    end
    if (addr == CLKREQ_ADDR) sel = DW'(clkreq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R10
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
  import itv_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 9,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tick_en,
  output logic [NCH-1:0] irq
);
  chan_cmd_t [NCH-1:0]   cmd;
  logic                  clkreq_we, clkreq_q;
  logic [NCH-1:0][DW-1:0] counts, terms;
  logic [NCH-1:0][7:0]   stats;

  itv_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .cmd(cmd), .clkreq_we(clkreq_we));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         clkreq_q <= 1'b0;
    else if (clkreq_we) clkreq_q <= bus_wdata[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    itv_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cmd(cmd[i]), .wdata(bus_wdata),
      .tick(tick_en[i]), .clkreq(clkreq_q), .count(counts[i]),
      .term(terms[i]), .status(stats[i]), .irq(irq[i]));
  end

  itv_rdmux #(.NCH(NCH), .AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .counts(counts), .terms(terms), .stats(stats), .clkreq(clkreq_q),
    .rdata(bus_rdata));
endmodule

// File: tb/sim_interval_timer_bank.sv
module sim_interval_timer_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = '0;
  logic [3:0]  irq;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  logic [8:0]  adr_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  interval_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq));

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && rst_n && exp_q.size() > 0) begin
      logic [31:0] e;
      logic [8:0]  a;
      string       t;
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (bus_rdata !== e) begin
        miscompares++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, a, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_tick(input logic [8:0] a, input logic [31:0] d, input int ch);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en[ch] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en[ch] = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); adr_q.push_back(a); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int ch, input int n);
    repeat (n) begin
      @(negedge clk);
      tick_en[ch] = 1'b1;
    end
    @(negedge clk);
    tick_en[ch] = 1'b0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string t);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(9'h010, 32'h01, "R11 status ch0");
    rd(9'h018, 32'hFFFF_FFFF, "R11 terminal ch0");
    rd(9'h100, 32'h0, "R11 clock request");
    rd(9'h0D4, 32'h0, "R11 count ch3");
    chk_irq(4'b0000, "R11 irq");
    // map: write-only and unmapped read as zero
    rd(9'h004, 32'h0, "R1 enable offset reads 0");
    rd(9'h024, 32'h0, "R1 unmapped offset");
    rd(9'h104, 32'h0, "R1 unmapped top");
    // gating by clock request
    wr(9'h004, 32'h1234_5678);
    rd(9'h010, 32'h12, "R2 enable any data");
    ticks(0, 4);
    rd(9'h014, 32'h0, "R3 held without clock request");
    wr(9'h100, 32'h1);
    rd(9'h100, 32'h1, "R1 clock request readback");
    ticks(0, 5);
    rd(9'h014, 32'h5, "R3 counts ticks");
    wr(9'h008, 32'h0);
    ticks(0, 3);
    rd(9'h014, 32'h5, "R3 disable freezes");
    rd(9'h010, 32'h01, "R7 idle after disable");
    // continuous channel 1, terminal 3
    wr(9'h058, 32'd3);
    wr(9'h05C, 32'h1);
    wr(9'h044, 32'h0);
    ticks(1, 2);
    rd(9'h054, 32'd2, "R3 ch1 count");
    rd(9'h050, 32'h52, "R7 active ie");
    chk_irq(4'b0000, "R8 no irq before event");
    ticks(1, 1);
    rd(9'h054, 32'd0, "R5 wrap to zero");
    rd(9'h050, 32'hD2, "R4 pending set");
    chk_irq(4'b0010, "R8 irq asserted");
    ticks(1, 2);
    rd(9'h054, 32'd2, "R5 keeps running");
    wr(9'h060, 32'h7F);
    rd(9'h050, 32'hD2, "R8 ack without bit7 ignored");
    wr(9'h060, 32'h80);
    rd(9'h050, 32'h52, "R8 ack clears");
    chk_irq(4'b0000, "R8 irq cleared");
    wr(9'h05C, 32'h0);
    ticks(1, 1);
    rd(9'h050, 32'h92, "R5 second period event");
    chk_irq(4'b0000, "R8 masked irq");
    // reset command keeps settings
    wr(9'h040, 32'hDEAD_BEEF);
    rd(9'h050, 32'h12, "R9 reset keeps enable clears pending");
    rd(9'h054, 32'h0, "R9 count cleared");
    rd(9'h058, 32'd3, "R9 terminal kept");
    // collision of ack and event on channel 2
    wr(9'h098, 32'd1);
    wr(9'h09C, 32'h1);
    wr(9'h084, 32'h0);
    ticks(2, 1);
    rd(9'h090, 32'hD2, "R4 terminal one fires on first tick");
    wr_tick(9'h0A0, 32'h80, 2);
    rd(9'h090, 32'hD2, "R8 event beats ack");
    chk_irq(4'b0100, "R8 irq held");
    wr(9'h0A0, 32'h80);
    rd(9'h090, 32'h52, "R8 plain ack clears");
    // one-shot channel 3
    wr(9'h0CC, 32'h1);
    wr(9'h0D8, 32'd1);
    wr(9'h0C4, 32'h0);
    rd(9'h0D0, 32'h32, "R7 active one-shot");
    ticks(3, 1);
    rd(9'h0D0, 32'hA1, "R6 idle after event");
    rd(9'h0D4, 32'd1, "R6 count parks at terminal");
    ticks(3, 2);
    rd(9'h0D4, 32'd1, "R6 no further counting");
    chk_irq(4'b0000, "R8 ie off ch3");
    wr(9'h0C0, 32'h0);
    rd(9'h0D0, 32'h21, "R9 mode kept after reset");
    rd(9'h0D4, 32'd0, "R9 count zero");
    wr(9'h0C4, 32'h0);
    ticks(3, 1);
    rd(9'h0D0, 32'hA1, "R6 rearmed one-shot fires");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R10 reads unanswered actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule